// File: doc/BRIEF.md
# Link Bring-up Speed Sequencer

This block steps a serial link through a conservative bring-up without software help. After a start pulse it writes a 4-bit maximum-speed cap of 1, so that training always begins at first-generation rate. Only after that does it raise the training enable. It then waits for a valid link-up. If the configured ceiling is generation 2, it widens the cap to 2.

Next it issues a directed speed-change request and polls the speed-change busy status until the link hardware clears it. The number of polls and the gap between them are both bounded. It then waits once more for a settled link before it reports done, together with the generation the link negotiated.

Any timeout routes to a recovery step. In that step the PHY receive data-enable and receive PLL-enable overrides are driven high together for a fixed hold time, then dropped, and the block reports fail. The hold time is given in microseconds and scaled by a clock-frequency parameter. A new start pulse after done or fail runs the whole sequence again.

Top module: `link_speed_seq`

## Requirements
- R1: Out of reset, speed_cap is 1, and train_en, spd_req, both overrides, done, fail and neg_gen are all 0.
- R2: On every start, speed_cap is rewritten to 1 one cycle before train_en rises. train_en is high in every cycle from then until done or fail.
- R3: The link counts as valid only when link_up is 1 and in_training is 0. While train_en is high, link_up with in_training also high never advances the sequence.
- R4: On the first valid link, speed_cap becomes 2 if max_gen equals 2. For max_gen values 0, 1 and 3 it stays 1.
- R5: After the first valid link, spd_req is high for exactly one cycle, and only once per run.
- R6: Starting from the cycle after spd_req, spd_busy is sampled once every POLL_GAP cycles, for at most SPD_TRIES samples. The first sample that reads 0 ends the wait. If all samples read 1, the run fails.
- R7: After the speed change, a second valid link must be seen before done is raised. Each link wait lasts at most LINK_TIMEOUT cycles, and expiry takes the failure path.
- R8: On failure, rx_data_ovr and rx_pll_ovr are both 1 for exactly CLK_KHZ*HOLD_US/1000 consecutive cycles, and both are 0 in every other cycle. fail rises in the cycle after they drop.
- R9: When done rises, neg_gen holds the value of cur_gen from the cycle of the confirming link check. neg_gen is 0 while a run is in progress and after a failure.
- R10: A start pulse while done or fail is high begins a new run from the speed-cap step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (acted on when idle, done or failed) |
| max_gen | input | 2 | Configured highest generation; only 2 enables widening |
| link_up | input | 1 | Link-up status from the link layer |
| in_training | input | 1 | Link training in progress status |
| spd_busy | input | 1 | Directed speed change still in progress |
| cur_gen | input | 4 | Currently negotiated generation |
| speed_cap | output | 4 | Maximum-speed cap field driven to the link |
| train_en | output | 1 | Training enable |
| spd_req | output | 1 | One-cycle directed speed-change request |
| rx_data_ovr | output | 1 | PHY receive data-enable override |
| rx_pll_ovr | output | 1 | PHY receive PLL-enable override |
| done | output | 1 | Bring-up succeeded |
| fail | output | 1 | Bring-up failed, after the recovery pulse |
| neg_gen | output | 4 | Generation captured at success |

## Verification
A wrong state shows up as an outcome that disagrees with the stimulus within one run. Examples are done where fail was due, a cap of 2 under a non-2 configuration, or a missing or doubled spd_req. A recovery pulse of the wrong length shows up as a wrong count of override cycles before fail rises. The counter boundaries are exercised with link delays and busy durations just inside and just outside the link timeout and the poll budget. Runs follow one another without a reset, so stale state from one outcome would corrupt the next run's cap or generation.

// File: rtl/link_speed_seq.sv
module link_speed_seq #(
  parameter int LINK_TIMEOUT = 1000000,
  parameter int SPD_TRIES    = 200,
  parameter int POLL_GAP     = 100,
  parameter int CLK_KHZ      = 100000,
  parameter int HOLD_US      = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] max_gen,
  input  logic       link_up,
  input  logic       in_training,
  input  logic       spd_busy,
  input  logic [3:0] cur_gen,
  output logic [3:0] speed_cap,
  output logic       train_en,
  output logic       spd_req,
  output logic       rx_data_ovr,
  output logic       rx_pll_ovr,
  output logic       done,
  output logic       fail,
  output logic [3:0] neg_gen
);
  localparam int HOLD_CYC = CLK_KHZ * HOLD_US / 1000;
  localparam int TW       = $clog2(SPD_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CAP, S_TRAIN, S_REQ, S_POLL, S_CONFIRM, S_RXRST, S_DONE, S_FAIL
  } state_t;

  state_t      st;
  logic [31:0] cnt;
  logic [TW-1:0] tries;
  logic        link_ok;

  assign link_ok     = link_up && !in_training;
  assign train_en    = (st == S_TRAIN) || (st == S_REQ) || (st == S_POLL) ||
                       (st == S_CONFIRM) || (st == S_RXRST);
  assign spd_req     = (st == S_REQ);
  assign rx_data_ovr = (st == S_RXRST);
  assign rx_pll_ovr  = (st == S_RXRST);
  assign done        = (st == S_DONE);
  assign fail        = (st == S_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      tries     <= '0;
      speed_cap <= 4'd1;
      neg_gen   <= 4'd0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) st <= S_CAP;
        S_CAP: begin
          speed_cap <= 4'd1;
          neg_gen   <= 4'd0;
          cnt       <= '0;
          st        <= S_TRAIN;
        end
        S_TRAIN:
          if (link_ok) begin
            if (max_gen == 2'd2) speed_cap <= 4'd2;
            st <= S_REQ;
          end else if (cnt == 32'(LINK_TIMEOUT - 1)) begin
            cnt <= '0;
            st  <= S_RXRST;
          end else cnt <= cnt + 1'b1;
        S_REQ: begin
          cnt   <= '0;
          tries <= '0;
          st    <= S_POLL;
        end
        S_POLL:
          if (cnt == 32'(POLL_GAP - 1)) begin
            cnt <= '0;
            if (!spd_busy) st <= S_CONFIRM;
            else if (tries == TW'(SPD_TRIES - 1)) st <= S_RXRST;
            else tries <= tries + 1'b1;
          end else cnt <= cnt + 1'b1;
        S_CONFIRM:
          if (link_ok) begin
            neg_gen <= cur_gen;
            st      <= S_DONE;
          end else if (cnt == 32'(LINK_TIMEOUT - 1)) begin
            cnt <= '0;
            st  <= S_RXRST;
          end else cnt <= cnt + 1'b1;
        S_RXRST:
          if (cnt == 32'(HOLD_CYC - 1)) begin
            cnt <= '0;
            st  <= S_FAIL;
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cap_gen1_at_train_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> speed_cap == 4'd1);

  p_widen_needs_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speed_cap[1]) |-> $past(link_up && !in_training));

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spd_req |=> !spd_req);

  p_done_needs_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(link_up && !in_training));

  p_fail_after_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(rx_data_ovr && rx_pll_ovr));

  p_gen_clear_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |-> neg_gen == 4'd0);
endmodule

// File: tb/tb_link_speed_seq.sv
module tb_link_speed_seq;
  localparam int TMO = 30, TRIES = 200, GAP = 2, KHZ = 10, HUS = 2000;
  localparam int HOLD = KHZ * HUS / 1000;
  localparam int NEVER = 100000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] max_gen = 0;
  logic spd_busy = 0;
  logic [3:0] speed_cap, neg_gen;
  logic train_en, spd_req, rx_data_ovr, rx_pll_ovr, done, fail;
  logic link_up, in_training;

  int L = 0, B = 0, lcnt = 0, bcnt = 0;
  bit stuck = 0, drop = 0, dropped = 0;
  int n_chk = 0, n_bad = 0;
  int ovr_cyc = 0, ovr_mis = 0, req_cyc = 0, cap_bad = 0;

  always #10 clk = ~clk;

  assign link_up     = train_en && !dropped && (stuck || lcnt >= L);
  assign in_training = train_en && (stuck || !link_up);

  link_speed_seq #(.LINK_TIMEOUT(TMO), .SPD_TRIES(TRIES), .POLL_GAP(GAP),
                   .CLK_KHZ(KHZ), .HOLD_US(HUS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_gen(max_gen),
    .link_up(link_up), .in_training(in_training), .spd_busy(spd_busy),
    .cur_gen(speed_cap), .speed_cap(speed_cap), .train_en(train_en),
    .spd_req(spd_req), .rx_data_ovr(rx_data_ovr), .rx_pll_ovr(rx_pll_ovr),
    .done(done), .fail(fail), .neg_gen(neg_gen));

  logic te_d = 0;
  always @(posedge clk) begin
    te_d <= train_en;
    lcnt <= train_en ? lcnt + 1 : 0;
    if (spd_req) begin spd_busy <= 1; bcnt <= B; end
    else if (spd_busy) begin
      if (bcnt == 0) begin spd_busy <= 0; if (drop) dropped <= 1; end
      else bcnt <= bcnt - 1;
    end
    if (rx_data_ovr && rx_pll_ovr) ovr_cyc <= ovr_cyc + 1;
    if (rx_data_ovr != rx_pll_ovr) ovr_mis <= ovr_mis + 1;
    if (spd_req) req_cyc <= req_cyc + 1;
    if (train_en && !te_d && speed_cap != 4'd1) cap_bad <= cap_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int g, input int l, input int b, input bit st, input bit dr);
    bit link_ok, exp_done;
    int w;
    @(negedge clk);
    max_gen = 2'(g); L = l; B = b; stuck = st; drop = dr; dropped = 0;
    ovr_cyc = 0; ovr_mis = 0; req_cyc = 0;
    start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(!done && !fail, "R10 run restarted", int'(done) + 2 * int'(fail), 0);
    w = 0;
    while (!done && !fail && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) begin chk(0, "R7 watchdog per run", w, 0); return; end
    link_ok  = !st && (l < TMO - 5);
    exp_done = link_ok && (b < NEVER) && !dr;
    chk(done == exp_done, "R6 R7 R3 outcome done", int'(done), int'(exp_done));
    chk(fail == !exp_done, "R8 outcome fail", int'(fail), int'(!exp_done));
    chk(speed_cap == ((link_ok && g == 2) ? 4'd2 : 4'd1), "R4 speed cap",
        int'(speed_cap), (link_ok && g == 2) ? 2 : 1);
    chk(req_cyc == (link_ok ? 1 : 0), "R5 spd_req cycles", req_cyc, link_ok ? 1 : 0);
    chk(ovr_cyc == (exp_done ? 0 : HOLD), "R8 override hold", ovr_cyc, exp_done ? 0 : HOLD);
    chk(ovr_mis == 0 && !rx_data_ovr, "R8 overrides paired", ovr_mis, 0);
    chk(neg_gen == (exp_done ? speed_cap : 4'd0), "R9 negotiated gen",
        int'(neg_gen), exp_done ? int'(speed_cap) : 0);
    chk(cap_bad == 0, "R2 cap 1 at train rise", cap_bad, 0);
  endtask

  initial begin
    int ls[5];
    int bs[4];
    ls = '{0, 7, TMO - 6, TMO + 5, -1};
    bs = '{0, 3, GAP * TRIES - 6, NEVER};
    repeat (3) @(negedge clk);
    chk(speed_cap == 1 && !train_en && !spd_req && !rx_data_ovr && !rx_pll_ovr
        && !done && !fail && neg_gen == 0, "R1 reset state", int'(speed_cap), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!train_en && !done && !fail, "R1 idle without start", int'(train_en), 0);
    for (int g = 0; g < 4; g++)
      for (int li = 0; li < 5; li++)
        for (int bi = 0; bi < 4; bi++)
          for (int d = 0; d < 2; d++)
            run(g, (li == 4) ? 0 : ls[li], bs[bi], li == 4, d[0]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL R7 global watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule